// File: doc/BRIEF.md
# Configurable Pixel Input Capture

This block is the input stage of a digital video transmitter. It samples a parallel pixel bus together with horizontal sync, vertical sync and data-enable, and turns it into one 24-bit pixel word per pixel clock, plus gated syncs, a pixel-valid strobe and an enable for the serial encoder that follows it.

The capture rules come from one control byte behind a small byte-wide register port. That byte chooses:

- whether the clock's rising or falling edge latches data;
- whether the bus is a full 24-bit word taken on one edge, or a 12-bit half word taken on both edges;
- whether each sync is passed on or held low;
- whether the encoder is powered and enabled.

Three read-only bytes sit next to the control byte and return a fixed identification value. The host writes the control byte once and then leaves the data path running on the pixel clock.

Top module: `pic_front`

## Requirements
- R1: After reset, the control byte at address 0x08 reads 0xFE. At the same time enc_en, pix_valid, pix_out, hsync_out, vsync_out and de_out are all low.
- R2: The control byte holds these fields:
  - bit 0: power (1 = run);
  - bit 1: edge select (1 = rising);
  - bit 2: width select (1 = 24-bit);
  - bit 3: a spare select bit;
  - bit 4: hsync enable;
  - bit 5: vsync enable;
  - bit 6: disable.

  A write to 0x08 stores bits 6:0, and reading 0x08 returns them. Bit 7 keeps its reset value of 1 whatever is written.
- R3: Reads of addresses 0x05, 0x06 and 0x07 return 0x00, 0x14 and 0x64. Writes to these addresses change nothing.
- R4: A write to any address other than 0x08 leaves the control byte unchanged. A read from any address outside 0x05 to 0x08 returns 0x00.
- R5: enc_en is high exactly when bit 0 is 1 and bit 6 is 0. It follows the control byte from the clock edge on which the write lands.
- R6: While enc_en is low, pix_valid, pix_out, hsync_out, vsync_out and de_out are low from the next rising edge on.
- R7: In 24-bit rising mode, the outputs after rising edge k carry the bus and sync/DE values present at rising edge k-1.
- R8: In 24-bit falling mode, the outputs after rising edge k carry the bus and sync/DE values present at the falling edge between rising edges k-1 and k.
- R9: In 12-bit rising mode, pix_out[11:0] is bus[11:0] at rising edge k-1, and pix_out[23:12] is bus[11:0] at the falling edge that follows it. Syncs and DE come from rising edge k-1.
- R10: In 12-bit falling mode, pix_out[11:0] is bus[11:0] at the falling edge before rising edge k, and pix_out[23:12] is bus[11:0] at rising edge k. Syncs and DE come from that falling edge.
- R11: With hsync enable at 0, hsync_out is low. With it at 1, hsync_out carries the captured sync. vsync enable controls vsync_out the same way. de_out always carries the captured DE.
- R12: pix_valid rises one clock after enc_en rises and stays high while enc_en stays high.
- R13: The spare select bit (bit 3) has no effect on pix_out, hsync_out, vsync_out or de_out.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges used for capture |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register address |
| reg_wr | input | 1 | Register write strobe, taken at a rising edge |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr, combinational |
| pix_in | input | 24 | Parallel pixel bus (bits 11:0 only in 12-bit mode) |
| hsync_in | input | 1 | Horizontal sync input |
| vsync_in | input | 1 | Vertical sync input |
| de_in | input | 1 | Data-enable input |
| pix_out | output | 24 | Rebuilt pixel word |
| hsync_out | output | 1 | Gated horizontal sync |
| vsync_out | output | 1 | Gated vertical sync |
| de_out | output | 1 | Captured data-enable |
| pix_valid | output | 1 | One strobe per clock while running |
| enc_en | output | 1 | Enable for the serial encoder |

## Verification
Faults in the capture path are caught within one or two clock periods:

- A wrong edge choice or swapped half-words shows up as pix_out taking a neighbouring half-cycle's bus value.
- A stuck sync gate shows up as hsync_out or vsync_out mismatching the gating bit on the first cycle where the captured sync is high.

Register faults show up at the port only when read:

- A corrupted control byte shows on reg_rdata on the next read.
- A corrupted power or disable bit shows on enc_en in the cycle after the write, and on pix_valid one cycle later.

The bench sweeps every control value, every register address, and all eight combinations of edge, width and sync gating with computed bus patterns, so each such fault appears within a few cycles of stimulus.

// File: rtl/pic_pkg.sv
package pic_pkg;
    localparam int PIX_W    = 24;
    localparam int HALF_W   = PIX_W / 2;
    localparam int NRSV     = 3;
    localparam logic [7:0] CTL_ADDR = 8'h08;
    localparam logic [7:0] RSV_BASE = 8'h05;
    localparam logic [8*NRSV-1:0] RSV_VALUE = 24'h641400;
    localparam logic [7:0] CTL_RESET = 8'hFE;

    typedef struct packed {
        logic spare7;
        logic tx_off;
        logic vs_en;
        logic hs_en;
        logic aux_sel;
        logic wide;
        logic rise_sel;
        logic run;
    } ctl_t;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             hs;
        logic             vs;
        logic             de;
    } sample_t;

    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             hs;
        logic             vs;
        logic             de;
        logic             valid;
    } out_t;
endpackage

// File: rtl/pic_ctrl.sv
module pic_ctrl
    import pic_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] reg_addr,
    input  logic       reg_wr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output ctl_t       ctl
);
    ctl_t ctl_d, ctl_q;
    logic [NRSV-1:0] rsv_hit;
    logic [7:0]      rsv_byte [NRSV];

    always_comb begin
        ctl_d = ctl_q;
        if (reg_wr && reg_addr == CTL_ADDR) begin
            ctl_d = ctl_t'({ctl_q.spare7, reg_wdata[6:0]});
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= ctl_t'(CTL_RESET);
        else        ctl_q <= ctl_d;
    end

    // Fixed identification bytes, one per address above the base
    for (genvar g = 0; g < NRSV; g++) begin : g_rsv
        assign rsv_hit[g]  = (reg_addr == RSV_BASE + 8'(g));
        assign rsv_byte[g] = RSV_VALUE[8*g +: 8];
    end

    always_comb begin
        reg_rdata = 8'h00;
        if (reg_addr == CTL_ADDR) reg_rdata = ctl_q;
        for (int i = 0; i < NRSV; i++) begin
            if (rsv_hit[i]) reg_rdata = rsv_byte[i];
        end
    end

    assign ctl = ctl_q;
endmodule

// File: rtl/pic_capture.sv
module pic_capture
    import pic_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  logic    rise_sel,
    input  logic    wide,
    input  sample_t bus,
    output sample_t word
);
    sample_t rise_d, rise_q;
    sample_t fall_q;
    sample_t chosen;
    logic [HALF_W-1:0] hi_half;

    always_comb rise_d = bus;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rise_q <= '0;
        else        rise_q <= rise_d;
    end

    always_ff @(negedge clk or negedge rst_n) begin
        if (!rst_n) fall_q <= '0;
        else        fall_q <= bus;
    end

    always_comb begin
        chosen  = rise_sel ? rise_q : fall_q;
        // The opposite edge supplies the upper half in narrow mode
        hi_half = rise_sel ? fall_q.pix[HALF_W-1:0] : bus.pix[HALF_W-1:0];
        word    = chosen;
        if (!wide) begin
            word.pix = {hi_half, chosen.pix[HALF_W-1:0]};
        end
    end
endmodule

// File: rtl/pic_front.sv
module pic_front
    import pic_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic [7:0]  reg_addr,
    input  logic        reg_wr,
    input  logic [7:0]  reg_wdata,
    output logic [7:0]  reg_rdata,
    input  logic [23:0] pix_in,
    input  logic        hsync_in,
    input  logic        vsync_in,
    input  logic        de_in,
    output logic [23:0] pix_out,
    output logic        hsync_out,
    output logic        vsync_out,
    output logic        de_out,
    output logic        pix_valid,
    output logic        enc_en
);
    ctl_t    ctl;
    sample_t bus;
    sample_t word;
    out_t    out_d, out_q;

    pic_ctrl u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .ctl       (ctl)
    );

    assign bus = '{pix: pix_in, hs: hsync_in, vs: vsync_in, de: de_in};

    pic_capture u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .rise_sel (ctl.rise_sel),
        .wide     (ctl.wide),
        .bus      (bus),
        .word     (word)
    );

    assign enc_en = ctl.run & ~ctl.tx_off;

    always_comb begin
        out_d = '0;
        if (enc_en) begin
            out_d.pix   = word.pix;
            out_d.hs    = word.hs & ctl.hs_en;
            out_d.vs    = word.vs & ctl.vs_en;
            out_d.de    = word.de;
            out_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign pix_out   = out_q.pix;
    assign hsync_out = out_q.hs;
    assign vsync_out = out_q.vs;
    assign de_out    = out_q.de;
    assign pix_valid = out_q.valid;
endmodule

// File: rtl/pic_front_chk.sv
module pic_front_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [7:0]  reg_addr,
    input logic        reg_wr,
    input logic [7:0]  reg_wdata,
    input logic [7:0]  reg_rdata,
    input logic [23:0] pix_out,
    input logic        hsync_out,
    input logic        vsync_out,
    input logic        de_out,
    input logic        pix_valid,
    input logic        enc_en,
    input logic        hs_gate,
    input logic        vs_gate
);
    p_enable_follows_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == 8'h08) |=> (enc_en == ($past(reg_wdata[0]) && !$past(reg_wdata[6]))));

    p_off_silent_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !enc_en |=> (!pix_valid && pix_out == '0 && !hsync_out && !vsync_out && !de_out));

    p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        enc_en |=> pix_valid);

    p_hs_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !hs_gate |=> !hsync_out);

    p_vs_gated_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !vs_gate |=> !vsync_out);

    p_id_byte_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h07) |-> (reg_rdata == 8'h64));

    p_unmapped_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr < 8'h05 || reg_addr > 8'h08) |-> (reg_rdata == 8'h00));

    p_spare_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == 8'h08) |-> reg_rdata[7]);
endmodule

bind pic_front pic_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_addr  (reg_addr),
    .reg_wr    (reg_wr),
    .reg_wdata (reg_wdata),
    .reg_rdata (reg_rdata),
    .pix_out   (pix_out),
    .hsync_out (hsync_out),
    .vsync_out (vsync_out),
    .de_out    (de_out),
    .pix_valid (pix_valid),
    .enc_en    (enc_en),
    .hs_gate   (ctl.hs_en),
    .vs_gate   (ctl.vs_en)
);

// File: tb/pic_front_bench.sv
`timescale 1ns/1ps
module pic_front_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_wdata = '0;
    logic [7:0]  reg_rdata;
    logic [23:0] pix_in = '0;
    logic        hsync_in = 1'b0, vsync_in = 1'b0, de_in = 1'b0;
    logic [23:0] pix_out;
    logic        hsync_out, vsync_out, de_out, pix_valid, enc_en;

    int checks = 0;
    int errors = 0;
    localparam int NS = 40;
    logic [26:0] rv [NS];
    logic [26:0] fv [NS];

    always #5 clk = ~clk;

    pic_front u_pic_front (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_reg(logic [7:0] a, logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    function automatic logic [7:0] exp_read(logic [7:0] a, logic [7:0] ctlv);
        case (a)
            8'h05: return 8'h00;
            8'h06: return 8'h14;
            8'h07: return 8'h64;
            8'h08: return ctlv;
            default: return 8'h00;
        endcase
    endfunction

    task automatic rd_chk(string req, logic [7:0] a, logic [7:0] exp);
        @(negedge clk);
        reg_addr = a;
        #1;
        chk(req, {24'h0, reg_rdata}, {24'h0, exp});
    endtask

    task automatic drive(logic [26:0] v);
        {pix_in, hsync_in, vsync_in, de_in} = v;
    endtask

    // Runs NS clocks of patterns; cfg gives the control byte in use
    task automatic stream(string req, logic [7:0] cfg, int seed);
        logic on, rs, wd, he, ve;
        logic [23:0] ep;
        logic [2:0]  es;
        logic [26:0] src;
        on = cfg[0] & ~cfg[6]; rs = cfg[1]; wd = cfg[2]; he = cfg[4]; ve = cfg[5];
        for (int k = 0; k < NS; k++) begin
            rv[k] = 27'(k * 32'h2A5F1 + seed * 32'h1357);
            fv[k] = 27'(k * 32'h91E37 + seed * 32'h0BAD + 32'h5);
        end
        for (int k = 0; k < NS; k++) begin
            @(negedge clk); #1 drive(rv[k]);
            @(posedge clk); #1 drive(fv[k]);
            #1;
            if (k >= 2) begin
                src = rs ? rv[k-1] : fv[k-1];
                if (wd) ep = src[26:3];
                else if (rs) ep = {fv[k-1][14:3], rv[k-1][14:3]};
                else ep = {rv[k][14:3], fv[k-1][14:3]};
                es = {src[2] & he, src[1] & ve, src[0]};
                if (!on) begin ep = '0; es = '0; end
                chk(req, {8'h0, pix_out}, {8'h0, ep});
                chk(req, {28'h0, hsync_out, vsync_out, de_out, pix_valid}, {28'h0, es, on});
            end
        end
    endtask

    initial begin
        #1_500_000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] cur;
        logic [7:0] cfg;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        // R1 reset state
        rd_chk("R1 reset ctl", 8'h08, 8'hFE);
        chk("R1 reset outputs", {7'h0, enc_en, pix_valid, pix_out}, 32'h0);
        // R2/R5 every control value
        for (int v = 0; v < 256; v++) begin
            wr_reg(8'h08, 8'(v));
            reg_addr = 8'h08; #1;
            chk("R2 readback", {24'h0, reg_rdata}, {24'h0, 1'b1, 7'(v)});
            chk("R5 enc_en", {31'h0, enc_en}, {31'h0, v[0] & ~v[6]});
        end
        cur = 8'hFE;
        wr_reg(8'h08, 8'h7E);
        cur = 8'hFE;
        // R3 writes to reserved bytes ignored
        wr_reg(8'h05, 8'hFF); wr_reg(8'h06, 8'hAA); wr_reg(8'h07, 8'h00);
        // R4 write to unmapped addresses leaves control byte alone
        wr_reg(8'h09, 8'h01); wr_reg(8'h00, 8'h01); wr_reg(8'hFF, 8'h55);
        for (int a = 0; a < 256; a++) begin
            rd_chk((a >= 5 && a <= 7) ? "R3 reserved read" : "R4 address read",
                   8'(a), exp_read(8'(a), cur));
        end
        // R12 valid one clock after enable
        wr_reg(8'h08, 8'h37);
        chk("R12 enc_en up", {31'h0, enc_en}, 32'h1);
        chk("R12 valid lags", {31'h0, pix_valid}, 32'h0);
        @(negedge clk);
        chk("R12 valid up", {31'h0, pix_valid}, 32'h1);
        // R7..R11, R13 sweep over edge, width and sync gating
        for (int m = 0; m < 8; m++) begin
            cfg = {1'b1, 1'b0, ~m[2], m[2], m[0], m[1], m[0], 1'b1};
            wr_reg(8'h08, cfg);
            if (m[1] && m[0])       stream("R7 wide rising", cfg, m);
            else if (m[1])          stream("R8 wide falling", cfg, m);
            else if (m[0])          stream("R9 narrow rising", cfg, m);
            else                    stream("R10 narrow falling", cfg, m);
            // same mode with spare bit flipped
            cfg[3] = ~cfg[3];
            wr_reg(8'h08, cfg);
            stream(m[2] ? "R11 sync gating" : "R13 spare bit", cfg, m + 8);
        end
        // R6 powered down, then disabled while powered
        wr_reg(8'h08, 8'h36);
        stream("R6 power down", 8'h36, 20);
        wr_reg(8'h08, 8'h77);
        stream("R6 disabled", 8'h77, 21);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule